// File: doc/BRIEF.md
# Workspace Context-Switch Sequencer

This block performs the multi-cycle context switches of a 16-bit CPU whose general registers live in RAM, addressed through a workspace pointer (WP). Register Rn of a workspace is the word at WP + 2·n. One request selects one of four operations. A vectored branch loads a new WP and PC from a two-word vector found at the operand's effective address. A numbered trap loads its vector from a fixed table and also hands the operand's effective address to the handler. A return restores WP, PC and ST from the current workspace. An absolute jump loads PC from the effective address.

Requests arrive on a valid/ready handshake together with the caller's WP, PC and ST. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the sequencer is idle, so the requester is held back for the whole operation. Memory traffic uses a word-wide bus with valid/ready semantics. The sequencer raises `mem_req` and keeps the address, direction and write data fixed until the memory raises `mem_ready`. A read returns its data on `mem_rdata` in the cycle it completes. The new WP, PC and ST come out with a one-cycle `done` strobe, together with the nominal cycle cost of the operation.

Top module: `ws_ctx_seq`

## Requirements
- R1: `req_ready` is high only in idle. A request is taken on `req_valid && req_ready`. Until `done`, changes on the request inputs have no effect on the operation under way.
- R2: A bus transfer completes in a cycle with `mem_req && mem_ready`. While `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold their values.
- R3: The effective address (EA) is resolved in the caller's workspace before any vector read. Mode 0 (register) gives EA = WP + 2·n. Mode 1 (indirect) gives EA = the word stored at WP + 2·n. Modes 2 and 3 (symbolic) give EA = `req_sym`.
- R4: Op 0 (vectored branch) takes the new WP from the word at EA and the new PC from the word at EA + 2. ST is passed through unchanged.
- R5: Op 1 (trap n) takes the new WP from the word at 0x0040 + 4·n and the new PC from the next word. The new ST is the old ST with the flag mask 0x0200 set, which is bit 6 when the MSB is counted as bit 0.
- R6: Op 1 writes the EA itself, never the word it points to, into R11 of the new workspace (new WP + 22). This makes four bus writes, against three for op 0.
- R7: Ops 0 and 1 write the old WP to new WP + 26, the old PC to new WP + 28 and the old ST to new WP + 30.
- R8: Op 2 (return) reads the words at caller WP + 26, + 28 and + 30 into the new WP, PC and ST, and writes nothing.
- R9: Op 3 (jump) issues exactly one read of the EA and discards the data. It then returns PC = EA, with WP and ST unchanged.
- R10: `done` is high for exactly one cycle, which follows the final bus transfer. During that cycle `new_wp`, `new_pc` and `new_st` hold the result, and `base_cycles` reads 26, 36, 14 or 8 for op 0, 1, 2 or 3.
- R11: After reset the block is idle: `req_ready` is high, and `mem_req` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request valid |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_op | input | 2 | 0 vectored branch, 1 trap, 2 return, 3 jump |
| req_mode | input | 2 | 0 register, 1 indirect, 2/3 symbolic |
| req_reg | input | 4 | Operand register number |
| req_sym | input | 16 | Symbolic operand address |
| req_trap | input | 4 | Trap number |
| cur_wp | input | 16 | Caller workspace pointer |
| cur_pc | input | 16 | Caller program counter |
| cur_st | input | 16 | Caller status |
| mem_req | output | 1 | Bus transfer valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_ready | input | 1 | Memory accepts the transfer this cycle |
| mem_addr | output | 16 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the completing cycle |
| done | output | 1 | One-cycle completion strobe |
| new_wp | output | 16 | Resulting workspace pointer |
| new_pc | output | 16 | Resulting program counter |
| new_st | output | 16 | Resulting status |
| base_cycles | output | 6 | Nominal cycle cost of the finished operation |

## Verification
The assertions assume that the memory side drives `mem_ready` freely and returns `mem_rdata` in the same cycle as the completing read. They also assume that the requester does not expect `req_ready` during an operation. The bench stalls the bus at random on about a quarter of the cycles. It keeps `req_valid` high with scrambled fields during every operation. Operand registers, vectors and target workspaces are placed in separate address regions of the bench memory, so that no write of an operation can overwrite a word that the same operation reads.

// File: rtl/ws_ctx_pkg.sv
package ws_ctx_pkg;
  localparam int WORD_W   = 16;
  localparam int REG_IW   = 4;
  localparam int TRAP_IW  = 4;
  localparam int COST_W   = 6;
  localparam int IDX_LINK = 11;
  localparam int IDX_OWP  = 13;
  localparam int IDX_OPC  = 14;
  localparam int IDX_OST  = 15;

  typedef enum logic [1:0] {
    OPC_VBRANCH = 2'd0,
    OPC_TRAP    = 2'd1,
    OPC_RETURN  = 2'd2,
    OPC_JUMP    = 2'd3
  } ctx_op_e;

  typedef enum logic [1:0] {
    AM_REG = 2'd0,
    AM_IND = 2'd1,
    AM_SYM = 2'd2,
    AM_SYM2 = 2'd3
  } ctx_mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_EA, S_EA_IND, S_VEC_WP, S_VEC_PC,
    S_SAVE_EA, S_SAVE_WP, S_SAVE_PC, S_SAVE_ST,
    S_RET_WP, S_RET_PC, S_RET_ST, S_PROBE, S_DONE
  } ctx_state_e;
endpackage

// File: rtl/ws_word_addr.sv
module ws_word_addr #(
  parameter int AW = 16,
  parameter int IW = 4
) (
  input  logic [AW-1:0] base,
  input  logic [IW-1:0] idx,
  output logic [AW-1:0] addr
);
  localparam int SHW = IW + 1;
  logic [SHW-1:0] ofs;
  assign ofs  = {idx, 1'b0};
  assign addr = base + AW'(ofs);
endmodule

// File: rtl/ws_trap_vec.sv
module ws_trap_vec #(
  parameter int AW = 16,
  parameter int NW = 4,
  parameter logic [AW-1:0] BASE = 16'h0040
) (
  input  logic [NW-1:0] num,
  output logic [AW-1:0] wp_addr,
  output logic [AW-1:0] pc_addr
);
  logic [NW+1:0] ofs;
  assign ofs     = {num, 2'b00};
  assign wp_addr = BASE + AW'(ofs);
  assign pc_addr = wp_addr + AW'(2);
endmodule

// File: rtl/ws_cost.sv
module ws_cost
  import ws_ctx_pkg::*;
#(
  parameter int CW = 6,
  parameter int COST_VB = 26,
  parameter int COST_TRAP = 36,
  parameter int COST_RET = 14,
  parameter int COST_JUMP = 8
) (
  input  ctx_op_e       op,
  output logic [CW-1:0] cycles
);
  always_comb begin
    unique case (op)
      OPC_VBRANCH: cycles = CW'(COST_VB);
      OPC_TRAP:    cycles = CW'(COST_TRAP);
      OPC_RETURN:  cycles = CW'(COST_RET);
      default:     cycles = CW'(COST_JUMP);
    endcase
  end
endmodule

// File: rtl/ws_ctx_seq.sv
module ws_ctx_seq
  import ws_ctx_pkg::*;
#(
  parameter int AW = WORD_W,
  parameter int CW = COST_W,
  parameter logic [AW-1:0] TRAP_BASE = 16'h0040,
  parameter logic [AW-1:0] X_MASK = 16'h0200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [1:0]    req_mode,
  input  logic [REG_IW-1:0]  req_reg,
  input  logic [AW-1:0] req_sym,
  input  logic [TRAP_IW-1:0] req_trap,
  input  logic [AW-1:0] cur_wp,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] cur_st,
  output logic          mem_req,
  output logic          mem_we,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] new_wp,
  output logic [AW-1:0] new_pc,
  output logic [AW-1:0] new_st,
  output logic [CW-1:0] base_cycles
);
  ctx_state_e state;
  ctx_op_e    op_q;
  ctx_mode_e  mode_q;
  logic [REG_IW-1:0]  reg_q;
  logic [TRAP_IW-1:0] trap_q;
  logic [AW-1:0] sym_q, wp_q, pc_q, st_q, ea_q;
  logic [AW-1:0] nwp_q, npc_q, nst_q;

  logic [REG_IW-1:0] a_idx, b_idx;
  logic [AW-1:0] a_addr, b_addr, tv_wp, tv_pc;
  logic xfer;
  ctx_state_e after_ea;

  ws_word_addr #(.AW(AW), .IW(REG_IW)) u_caller_addr (
    .base(wp_q), .idx(a_idx), .addr(a_addr));

  ws_word_addr #(.AW(AW), .IW(REG_IW)) u_target_addr (
    .base(nwp_q), .idx(b_idx), .addr(b_addr));

  ws_trap_vec #(.AW(AW), .NW(TRAP_IW), .BASE(TRAP_BASE)) u_trap_vec (
    .num(trap_q), .wp_addr(tv_wp), .pc_addr(tv_pc));

  ws_cost #(.CW(CW)) u_cost (.op(op_q), .cycles(base_cycles));

  always_comb begin
    unique case (state)
      S_RET_WP: a_idx = REG_IW'(IDX_OWP);
      S_RET_PC: a_idx = REG_IW'(IDX_OPC);
      S_RET_ST: a_idx = REG_IW'(IDX_OST);
      default:  a_idx = reg_q;
    endcase
    unique case (state)
      S_SAVE_EA: b_idx = REG_IW'(IDX_LINK);
      S_SAVE_WP: b_idx = REG_IW'(IDX_OWP);
      S_SAVE_PC: b_idx = REG_IW'(IDX_OPC);
      default:   b_idx = REG_IW'(IDX_OST);
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_EA_IND: begin mem_req = 1'b1; mem_addr = a_addr; end
      S_VEC_WP: begin
        mem_req  = 1'b1;
        mem_addr = (op_q == OPC_TRAP) ? tv_wp : ea_q;
      end
      S_VEC_PC: begin
        mem_req  = 1'b1;
        mem_addr = (op_q == OPC_TRAP) ? tv_pc : ea_q + AW'(2);
      end
      S_SAVE_EA: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = b_addr; mem_wdata = ea_q; end
      S_SAVE_WP: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = b_addr; mem_wdata = wp_q; end
      S_SAVE_PC: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = b_addr; mem_wdata = pc_q; end
      S_SAVE_ST: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = b_addr; mem_wdata = st_q; end
      S_RET_WP, S_RET_PC, S_RET_ST: begin mem_req = 1'b1; mem_addr = a_addr; end
      S_PROBE:  begin mem_req = 1'b1; mem_addr = ea_q; end
      default: ;
    endcase
  end

  assign xfer      = mem_req && mem_ready;
  assign after_ea  = (op_q == OPC_JUMP) ? S_PROBE : S_VEC_WP;
  assign req_ready = (state == S_IDLE);
  assign done      = (state == S_DONE);
  assign new_wp    = nwp_q;
  assign new_pc    = npc_q;
  assign new_st    = nst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= OPC_VBRANCH;
      mode_q <= AM_REG;
      reg_q  <= '0;
      trap_q <= '0;
      sym_q  <= '0;
      wp_q   <= '0;
      pc_q   <= '0;
      st_q   <= '0;
      ea_q   <= '0;
      nwp_q  <= '0;
      npc_q  <= '0;
      nst_q  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= ctx_op_e'(req_op);
          mode_q <= ctx_mode_e'(req_mode);
          reg_q  <= req_reg;
          trap_q <= req_trap;
          sym_q  <= req_sym;
          wp_q   <= cur_wp;
          pc_q   <= cur_pc;
          st_q   <= cur_st;
          state  <= (ctx_op_e'(req_op) == OPC_RETURN) ? S_RET_WP : S_EA;
        end
        S_EA: begin
          if (mode_q == AM_IND) state <= S_EA_IND;
          else begin
            ea_q  <= (mode_q == AM_REG) ? a_addr : sym_q;
            state <= after_ea;
          end
        end
        S_EA_IND: if (xfer) begin ea_q <= mem_rdata; state <= after_ea; end
        S_VEC_WP: if (xfer) begin nwp_q <= mem_rdata; state <= S_VEC_PC; end
        S_VEC_PC: if (xfer) begin
          npc_q <= mem_rdata;
          state <= (op_q == OPC_TRAP) ? S_SAVE_EA : S_SAVE_WP;
        end
        S_SAVE_EA: if (xfer) state <= S_SAVE_WP;
        S_SAVE_WP: if (xfer) state <= S_SAVE_PC;
        S_SAVE_PC: if (xfer) state <= S_SAVE_ST;
        S_SAVE_ST: if (xfer) begin
          nst_q <= (op_q == OPC_TRAP) ? (st_q | X_MASK) : st_q;
          state <= S_DONE;
        end
        S_RET_WP: if (xfer) begin nwp_q <= mem_rdata; state <= S_RET_PC; end
        S_RET_PC: if (xfer) begin npc_q <= mem_rdata; state <= S_RET_ST; end
        S_RET_ST: if (xfer) begin nst_q <= mem_rdata; state <= S_DONE; end
        S_PROBE: if (xfer) begin
          nwp_q <= wp_q;
          npc_q <= ea_q;
          nst_q <= st_q;
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ws_ctx_seq_chk.sv
module ws_ctx_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [AW-1:0] mem_wdata,
  input logic          done,
  input logic [AW-1:0] new_st,
  input logic [CW-1:0] base_cycles,
  input logic [1:0]    op_q,
  input logic [AW-1:0] st_q
);
  // R1
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  // R2
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req && !req_ready);

  // R5
  trap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q == 2'd1 |-> new_st[AW-7]);

  // R4
  vbranch_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q == 2'd0 |-> new_st == st_q);

  // R10
  cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_q == 2'd1 |-> base_cycles == CW'(36));

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> req_ready && !done);
endmodule

bind ws_ctx_seq ws_ctx_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done),
  .new_st(new_st), .base_cycles(base_cycles), .op_q(op_q), .st_q(st_q));

// File: tb/ws_ctx_seq_test.sv
`timescale 1ns/1ps
module ws_ctx_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_op = '0, req_mode = '0;
  logic [3:0] req_reg = '0, req_trap = '0;
  logic [15:0] req_sym = '0, cur_wp = '0, cur_pc = '0, cur_st = '0;
  logic mem_req, mem_we;
  logic mem_ready = 1'b1;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic done;
  logic [15:0] new_wp, new_pc, new_st;
  logic [5:0] base_cycles;

  logic [15:0] mem [0:4095];
  logic poke_en = 1'b0;
  logic [15:0] poke_a = '0, poke_d = '0, probe_a = '0;
  int wr_cnt = 0, rd_cnt = 0, hit_cnt = 0;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  ws_ctx_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_mode(req_mode), .req_reg(req_reg), .req_sym(req_sym),
    .req_trap(req_trap), .cur_wp(cur_wp), .cur_pc(cur_pc), .cur_st(cur_st),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .new_wp(new_wp), .new_pc(new_pc), .new_st(new_st),
    .base_cycles(base_cycles));

  assign mem_rdata = mem[mem_addr[12:1]];

  always @(posedge clk) begin
    if (poke_en) mem[poke_a[12:1]] <= poke_d;
    if (mem_req && mem_ready && mem_we) begin
      mem[mem_addr[12:1]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_req && mem_ready && !mem_we) begin
      rd_cnt <= rd_cnt + 1;
      if (mem_addr == probe_a) hit_cnt <= hit_cnt + 1;
    end
  end

  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  function automatic logic [15:0] rdm(input logic [15:0] a);
    return mem[a[12:1]];
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = a; poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] op, input logic [1:0] mode, input logic [3:0] rn,
                       input logic [15:0] sym, input logic [3:0] tn,
                       input logic [15:0] wp, input logic [15:0] pc, input logic [15:0] st);
    logic [15:0] ea, ewp, epc, est;
    logic [5:0] ecost;
    int w0, h0;
    bit busy_bad, seen;
    ea = (mode == 2'd0) ? wp + 16'(2 * rn) : (mode == 2'd1) ? rdm(wp + 16'(2 * rn)) : sym;
    case (op)
      2'd0: begin ewp = rdm(ea); epc = rdm(ea + 16'd2); est = st; ecost = 6'd26; end
      2'd1: begin ewp = rdm(16'h0040 + 16'(4 * tn)); epc = rdm(16'h0042 + 16'(4 * tn));
                  est = st | 16'h0200; ecost = 6'd36; end
      2'd2: begin ewp = rdm(wp + 16'd26); epc = rdm(wp + 16'd28); est = rdm(wp + 16'd30);
                  ecost = 6'd14; end
      default: begin ewp = wp; epc = ea; est = st; ecost = 6'd8; end
    endcase
    @(negedge clk);
    probe_a = ea;
    w0 = wr_cnt; h0 = hit_cnt;
    req_valid = 1'b1; req_op = op; req_mode = mode; req_reg = rn; req_sym = sym;
    req_trap = tn; cur_wp = wp; cur_pc = pc; cur_st = st;
    @(negedge clk);
    // R1: scrambled request held during the operation must be ignored
    req_op = ~op; req_mode = ~mode; req_reg = ~rn; req_sym = ~sym; req_trap = ~tn;
    cur_wp = ~wp; cur_pc = ~pc; cur_st = ~st;
    busy_bad = 1'b0; seen = 1'b0;
    for (int k = 0; k < 400; k++) begin
      if (done) begin seen = 1'b1; break; end
      if (req_ready) busy_bad = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R1 ready low while busy", {15'd0, busy_bad}, 16'd0);
    chk("R10 done seen", {15'd0, seen}, 16'd1);
    chk("R10 new_wp", new_wp, ewp);
    chk("R10 new_pc", new_pc, epc);
    chk("R10 new_st", new_st, est);
    chk("R10 base_cycles", {10'd0, base_cycles}, {10'd0, ecost});
    @(negedge clk);
    chk("R10 done one cycle", {15'd0, done}, 16'd0);
    if (op == 2'd0) begin
      chk("R4 vbranch pc", new_pc, epc);
      chk("R7 saved wp", rdm(ewp + 16'd26), wp);
      chk("R7 saved pc", rdm(ewp + 16'd28), pc);
      chk("R7 saved st", rdm(ewp + 16'd30), st);
      chk("R6 vbranch writes", 16'(wr_cnt - w0), 16'd3);
    end else if (op == 2'd1) begin
      chk("R5 trap st", new_st, st | 16'h0200);
      chk("R6 link holds EA", rdm(ewp + 16'd22), ea);
      chk("R6 trap writes", 16'(wr_cnt - w0), 16'd4);
      chk("R7 saved wp", rdm(ewp + 16'd26), wp);
      chk("R7 saved pc", rdm(ewp + 16'd28), pc);
      chk("R7 saved st", rdm(ewp + 16'd30), st);
    end else if (op == 2'd2) begin
      chk("R8 return writes", 16'(wr_cnt - w0), 16'd0);
    end else begin
      chk("R9 single probe read", 16'(hit_cnt - h0), 16'd1);
      chk("R9 no writes", 16'(wr_cnt - w0), 16'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11
    chk("R11 ready after reset", {15'd0, req_ready}, 16'd1);
    chk("R11 no bus after reset", {15'd0, mem_req}, 16'd0);
    chk("R11 done low after reset", {15'd0, done}, 16'd0);
    rst_n = 1'b1;

    // R5/R6 trap 1 with register operand R1 in workspace 0x8300
    poke(16'h0044, 16'hFFD8);
    poke(16'h0046, 16'hFFF8);
    do_op(2'd1, 2'd0, 4'd1, 16'h0, 4'd1, 16'h8300, 16'h1234, 16'h8000);
    chk("R3 register EA in link", rdm(16'hFFD8 + 16'd22), 16'h8302);
    chk("R5 trap pc", new_pc, 16'hFFF8);
    // R3 indirect: R1 holds 0xFACE, word at 0xFACE must not be used
    poke(16'h8302, 16'hFACE);
    poke(16'hFACE, 16'h1357);
    do_op(2'd1, 2'd1, 4'd1, 16'h0, 4'd1, 16'h8300, 16'h2000, 16'h0000);
    chk("R3 indirect EA in link", rdm(16'hFFD8 + 16'd22), 16'hFACE);
    // R3 symbolic
    do_op(2'd1, 2'd2, 4'd0, 16'hFF00, 4'd1, 16'h8300, 16'h2000, 16'h0001);
    chk("R3 symbolic EA in link", rdm(16'hFFD8 + 16'd22), 16'hFF00);
    // R4 vectored branch through R4/R5
    poke(16'h8308, 16'hA010);
    poke(16'h830A, 16'h4242);
    do_op(2'd0, 2'd0, 4'd4, 16'h0, 4'd0, 16'h8300, 16'h3000, 16'h00F0);
    chk("R4 new wp from Rn", new_wp, 16'hA010);
    // R9 jump
    do_op(2'd3, 2'd2, 4'd0, 16'hA000, 4'd0, 16'h8300, 16'h3000, 16'h0033);
    // R8 return from the workspace saved above
    do_op(2'd2, 2'd0, 4'd0, 16'h0, 4'd0, 16'hA010, 16'h0000, 16'h0000);
    chk("R8 restored wp", new_wp, 16'h8300);

    for (int i = 0; i < 60; i++) begin
      logic [1:0] op, mode;
      logic [3:0] rn, tn;
      logic [15:0] wp, sym, vec;
      op = 2'($urandom % 4);
      mode = 2'($urandom % 4);
      rn = 4'($urandom % 15);
      tn = 4'($urandom % 16);
      wp = 16'h8300 + 16'(2 * ($urandom % 16));
      vec = 16'h9000 + 16'(4 * ($urandom % 32));
      sym = vec;
      if (mode == 2'd1) poke(wp + 16'(2 * rn), vec);
      if (op == 2'd0) begin
        if (mode == 2'd0) begin
          poke(wp + 16'(2 * rn), 16'hA000 + 16'(2 * ($urandom % 16)));
          poke(wp + 16'(2 * rn) + 16'd2, 16'($urandom) & 16'hFFFE);
        end else begin
          poke(vec, 16'hA000 + 16'(2 * ($urandom % 16)));
          poke(vec + 16'd2, 16'($urandom) & 16'hFFFE);
        end
      end else if (op == 2'd1) begin
        poke(16'h0040 + 16'(4 * tn), 16'hA000 + 16'(2 * ($urandom % 16)));
        poke(16'h0042 + 16'(4 * tn), 16'($urandom) & 16'hFFFE);
      end else if (op == 2'd2) begin
        poke(wp + 16'd26, 16'($urandom));
        poke(wp + 16'd28, 16'($urandom));
        poke(wp + 16'd30, 16'($urandom));
      end
      do_op(op, mode, rn, sym, tn, wp, 16'($urandom), 16'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule